// File: doc/BRIEF.md
# Latchable Parity Transceiver with Dual Checker

This block moves a 9-bit word (8 data bits and 1 parity bit) between two buses, A and B. Each side has a transparent latch. The latch is built as a bypass mux in front of a clock-enabled hold register. While its enable is high the latch passes the live word, and while the enable is low it presents the stored word. Two active-low enables choose the direction of transfer. Each bus is modelled as three parts:

- a separate input vector;
- a separate output vector;
- a drive-qualifier output.

A mode input chooses what goes out on the destination parity line:

- In generate mode, the parity computed from the source latch's data bits.
- In pass-through mode, the source parity bit, unchanged.

A polarity input chooses even or odd parity. Each side has its own checker, and both run at the same time. Each checker compares the parity computed from its own latch contents with the parity bit held in that latch, and drives an active-low error flag. When the destination latch is also open, the word being driven loops back through it, so the destination checker verifies what leaves the block.

If both direction enables are low, the combination is rejected. Neither bus is driven and a separate flag is raised.

Top module: `par_xcvr`

## Requirements
- R1: A synchronous active-low reset clears both hold registers to zero. Right after reset, with both latches closed, both enables high and even parity, neither bus is driven, all outputs are zero, and both error flags are high.
- R2: While a side's latch enable is high, that side's latch presents the live bus word in the same cycle. With `ab_en_n` low, `b_out` equals `a_in`. With `ba_en_n` low, `a_out` equals `b_in`.
- R3: While a side's latch enable is low, that side presents the word captured at the last rising clock edge on which its enable was high. Changes on the live bus have no effect on the forwarded word.
- R4: With `odd_sel` low (even parity), the generated bit is the XOR of the 8 data bits. With `odd_sel` high it is the inverse of that XOR.
- R5: With `pass_thru` low (generate mode), the destination parity output equals the generated parity of the source latch's data bits.
- R6: With `pass_thru` high, the destination parity output equals the parity bit held in or passed by the source latch, and the data bits are forwarded unchanged.
- R7: Each side's error flag is low exactly when the generated parity of that side's latch data differs from that side's latch parity bit. This holds in both modes.
- R8: With `ab_en_n` low and `ba_en_n` high, only `b_drv` is high. With `ba_en_n` low and `ab_en_n` high, only `a_drv` is high. With both enables high, neither is high. An undriven bus output reads zero.
- R9: With both enables low, neither bus is driven, both bus outputs read zero, and `cfg_bad` is high. `cfg_bad` is low in every other combination.
- R10: When the destination latch is open during a transfer, the driven word passes through it. The destination error flag then checks the driven word. In generate mode that flag stays high. In pass-through mode it follows the source error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 8 | Bus A data sensed from the pins |
| a_par_in | input | 1 | Bus A parity sensed from the pins |
| b_in | input | 8 | Bus B data sensed from the pins |
| b_par_in | input | 1 | Bus B parity sensed from the pins |
| ab_en_n | input | 1 | Active-low enable: drive bus B from the A latch |
| ba_en_n | input | 1 | Active-low enable: drive bus A from the B latch |
| pass_thru | input | 1 | 1 = forward source parity, 0 = generate parity |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| lat_a_en | input | 1 | A latch transparent while high |
| lat_b_en | input | 1 | B latch transparent while high |
| a_out | output | 8 | Data driven onto bus A |
| a_par_out | output | 1 | Parity driven onto bus A |
| a_drv | output | 1 | Bus A output enable |
| b_out | output | 8 | Data driven onto bus B |
| b_par_out | output | 1 | Parity driven onto bus B |
| b_drv | output | 1 | Bus B output enable |
| err_a_n | output | 1 | Side A parity mismatch, active low |
| err_b_n | output | 1 | Side B parity mismatch, active low |
| cfg_bad | output | 1 | Both direction enables low |

## Verification
The only internal state is the two hold registers. A wrong value in either one becomes visible at the ports in the first cycle that its latch is closed, in one of two ways:
- as wrong forwarded data or parity, if that side is the source;
- as a wrong error flag, in every direction.

The reference model is therefore compared on every clock, and the stimulus closes each latch right after loading a known word. The loop-back cases expose a checker that looks at the live pins instead of the driven word. In generate mode the destination flag stays high, and in pass-through mode it mirrors the source flag.

// File: rtl/par_xcvr.sv
module par_xcvr #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] a_in,
  input  logic          a_par_in,
  input  logic [DW-1:0] b_in,
  input  logic          b_par_in,
  input  logic          ab_en_n,
  input  logic          ba_en_n,
  input  logic          pass_thru,
  input  logic          odd_sel,
  input  logic          lat_a_en,
  input  logic          lat_b_en,
  output logic [DW-1:0] a_out,
  output logic          a_par_out,
  output logic          a_drv,
  output logic [DW-1:0] b_out,
  output logic          b_par_out,
  output logic          b_drv,
  output logic          err_a_n,
  output logic          err_b_n,
  output logic          cfg_bad
);
  localparam int W = DW + 1;

  function automatic logic gen_par(input logic [DW-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  logic [W-1:0] hold_a, hold_b, raw_a, raw_b, fwd_a, fwd_b, view_a, view_b;

  assign cfg_bad = !ab_en_n && !ba_en_n;
  assign b_drv   = !ab_en_n && ba_en_n;
  assign a_drv   = !ba_en_n && ab_en_n;

  assign raw_a = lat_a_en ? {a_par_in, a_in} : hold_a;
  assign raw_b = lat_b_en ? {b_par_in, b_in} : hold_b;

  assign fwd_b = {pass_thru ? raw_a[DW] : gen_par(raw_a[DW-1:0], odd_sel), raw_a[DW-1:0]};
  assign fwd_a = {pass_thru ? raw_b[DW] : gen_par(raw_b[DW-1:0], odd_sel), raw_b[DW-1:0]};

  assign view_a = (a_drv && lat_a_en) ? fwd_a : raw_a;
  assign view_b = (b_drv && lat_b_en) ? fwd_b : raw_b;

  assign {b_par_out, b_out} = b_drv ? fwd_b : '0;
  assign {a_par_out, a_out} = a_drv ? fwd_a : '0;

  assign err_a_n = gen_par(view_a[DW-1:0], odd_sel) == view_a[DW];
  assign err_b_n = gen_par(view_b[DW-1:0], odd_sel) == view_b[DW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_a <= '0;
      hold_b <= '0;
    end else begin
      if (lat_a_en) hold_a <= view_a;
      if (lat_b_en) hold_b <= view_b;
    end
  end
endmodule

// File: rtl/par_xcvr_chk.sv
module par_xcvr_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] a_in,
  input logic          a_par_in,
  input logic          ab_en_n,
  input logic          ba_en_n,
  input logic          pass_thru,
  input logic          odd_sel,
  input logic          lat_a_en,
  input logic          lat_b_en,
  input logic [DW-1:0] a_out,
  input logic          a_drv,
  input logic [DW-1:0] b_out,
  input logic          b_par_out,
  input logic          b_drv,
  input logic          err_a_n,
  input logic          err_b_n,
  input logic          cfg_bad
);
  a_r9_no_drive_when_bad: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad |-> (!a_drv && !b_drv && a_out == '0 && b_out == '0));

  a_r8_b_direction: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_en_n && ba_en_n) |-> (b_drv && !a_drv && !cfg_bad));

  a_r3_b_out_held: assert property (@(posedge clk) disable iff (!rst_n)
    (b_drv && !lat_a_en) |=> (!(b_drv && !lat_a_en) || $stable(b_out)));

  a_r5_generate: assert property (@(posedge clk) disable iff (!rst_n)
    (b_drv && !pass_thru && lat_a_en) |-> (b_par_out == ((^a_in) ^ odd_sel)));

  a_r6_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (b_drv && pass_thru && lat_a_en) |-> (b_par_out == a_par_in && b_out == a_in));

  a_r10_loopback_gen: assert property (@(posedge clk) disable iff (!rst_n)
    (b_drv && !pass_thru && lat_b_en) |-> err_b_n);

  a_r10_loopback_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (b_drv && pass_thru && lat_b_en) |-> (err_b_n == err_a_n));
endmodule

bind par_xcvr par_xcvr_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_par_in(a_par_in),
  .ab_en_n(ab_en_n), .ba_en_n(ba_en_n), .pass_thru(pass_thru), .odd_sel(odd_sel),
  .lat_a_en(lat_a_en), .lat_b_en(lat_b_en), .a_out(a_out), .a_drv(a_drv),
  .b_out(b_out), .b_par_out(b_par_out), .b_drv(b_drv),
  .err_a_n(err_a_n), .err_b_n(err_b_n), .cfg_bad(cfg_bad)
);

// File: tb/tb_par_xcvr.sv
`timescale 1ns/1ps
module tb_par_xcvr;
  logic clk = 0, rst_n = 0;
  logic [7:0] a_in = 0, b_in = 0;
  logic a_par_in = 0, b_par_in = 0;
  logic ab_en_n = 1, ba_en_n = 1, pass_thru = 0, odd_sel = 0, lat_a_en = 0, lat_b_en = 0;
  logic [7:0] a_out, b_out;
  logic a_par_out, b_par_out, a_drv, b_drv, err_a_n, err_b_n, cfg_bad;

  int tests = 0, fails = 0;
  string req = "R1";
  logic [8:0] ma = 0, mb = 0;

  always #2 clk = ~clk;

  par_xcvr dut (.*);

  function automatic logic p(input logic [7:0] d, input logic o);
    int n = 0;
    for (int i = 0; i < 8; i++) n += d[i];
    return (n % 2 == 1) ^ o;
  endfunction

  // model views: word = {par, data}
  logic [8:0] e_va, e_vb, e_aout, e_bout;
  logic e_ad, e_bd, e_bad;
  always_comb begin
    logic [8:0] la, lb;
    e_bad = (ab_en_n == 0) && (ba_en_n == 0);
    e_bd = (ab_en_n == 0) && !e_bad;
    e_ad = (ba_en_n == 0) && !e_bad;
    la = lat_a_en ? {a_par_in, a_in} : ma;
    lb = lat_b_en ? {b_par_in, b_in} : mb;
    e_va = la; e_vb = lb; e_aout = 0; e_bout = 0;
    if (e_bd) begin
      e_bout = {pass_thru ? la[8] : p(la[7:0], odd_sel), la[7:0]};
      if (lat_b_en) e_vb = e_bout;
    end
    if (e_ad) begin
      e_aout = {pass_thru ? lb[8] : p(lb[7:0], odd_sel), lb[7:0]};
      if (lat_a_en) e_va = e_aout;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin ma = 0; mb = 0; end
    else begin
      if (lat_a_en) ma = e_va;
      if (lat_b_en) mb = e_vb;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("a_out", {a_par_out, a_out}, e_aout);
    chk("b_out", {b_par_out, b_out}, e_bout);
    chk("drv", {a_drv, b_drv, cfg_bad}, {e_ad, e_bd, e_bad});
    chk("err_a_n", err_a_n, p(e_va[7:0], odd_sel) == e_va[8]);
    chk("err_b_n", err_b_n, p(e_vb[7:0], odd_sel) == e_vb[8]);
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    req = "R1"; @(negedge clk);
    chk("R1 reset outs", {a_out, b_out, a_drv, b_drv, err_a_n, err_b_n}, {8'h0, 8'h0, 2'b00, 2'b11});
    cyc(1);
    req = "R2"; ab_en_n = 0; lat_a_en = 1;
    for (int i = 0; i < 16; i++) begin
      a_in = 8'(i * 37 + 5); a_par_in = i[0]; odd_sel = i[1];
      cyc(1); @(negedge clk); chk("R2 b_out", b_out, a_in); chk("R4 par", b_par_out, (^a_in) ^ odd_sel);
    end
    req = "R3"; a_in = 8'h5A; odd_sel = 0; cyc(1); lat_a_en = 0;
    for (int i = 0; i < 4; i++) begin
      a_in = 8'(i * 91); cyc(1); @(negedge clk); chk("R3 held", b_out, 8'h5A);
    end
    req = "R6"; pass_thru = 1; lat_a_en = 1; a_in = 8'h07; a_par_in = 0; cyc(1);
    @(negedge clk); chk("R6 par", b_par_out, 1'b0); chk("R7 err_a", err_a_n, 1'b0);
    req = "R10"; lat_b_en = 1; cyc(1); @(negedge clk); chk("R10 pass err_b", err_b_n, 1'b0);
    pass_thru = 0; cyc(1); @(negedge clk); chk("R10 gen err_b", err_b_n, 1'b1);
    req = "R5"; lat_b_en = 0; ab_en_n = 1; ba_en_n = 0; lat_b_en = 1;
    for (int i = 0; i < 8; i++) begin
      b_in = 8'(i * 53 + 1); b_par_in = i[1]; odd_sel = i[0]; lat_a_en = i[2];
      cyc(1); @(negedge clk); chk("R5 a_par", a_par_out, (^b_in) ^ odd_sel);
    end
    req = "R7"; ba_en_n = 1; lat_a_en = 1; lat_b_en = 1;
    for (int i = 0; i < 8; i++) begin
      a_in = 8'(i * 29); b_in = 8'(i * 71); a_par_in = i[0]; b_par_in = i[1]; odd_sel = i[2];
      pass_thru = i[0];
      cyc(1);
    end
    req = "R9"; ab_en_n = 0; ba_en_n = 0; cyc(1); @(negedge clk);
    chk("R9 bad", {cfg_bad, a_drv, b_drv}, 3'b100);
    req = "R8"; ab_en_n = 1; ba_en_n = 1; cyc(1); @(negedge clk);
    chk("R8 idle", {cfg_bad, a_drv, b_drv, a_out, b_out}, 19'h0);
    cyc(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule